// File: doc/BRIEF.md
# Windowed Bus Address Translator

This block sits on the system-bus side of a bus bridge and classifies each request address into one of four outbound spaces: a 256 MB memory window, a 1 MB IO window, a single configuration-address register location and a single configuration-data register location. Any other address is reported as a miss.

For memory and IO accesses the block also produces a translated outbound address. The memory window is cut into eight 32 MB slices. Each slice has its own 7-bit remap value, which replaces the top address bits. A separate 12-bit value moves the IO window to another 1 MB region. One global enable switches all remapping on or off. A simple register-write port loads the remap values and the enable. The result is registered, so it appears one cycle after the request.

Top module: `addr_window_xlate`

## Requirements
- R1: A valid request with address bits [31:28] equal to 0x8 reports the memory space, which is `rspSpace` bit 0.
- R2: A valid request with address bits [31:20] equal to 0xA00 reports the IO space, which is `rspSpace` bit 1.
- R3: The exact address 0xA010_0000 reports `rspSpace` bit 2. The exact address 0xA020_0000 reports `rspSpace` bit 3. In both cases `rspAddr` equals the request address.
- R4: Any other address asserts `rspMiss`, drives `rspSpace` to 0 and returns the request address unchanged on `rspAddr`.
- R5: With the enable set, a memory request yields `rspAddr` = {slice value[6:0], addr[24:0]}. The slice is chosen by addr[27:25]. For example, value 0x75 in slice 0 maps 0x8000_0000 to 0xEA00_0000.
- R6: With the enable set, an IO request yields `rspAddr` = {IO value[11:0], addr[19:0]}.
- R7: With the enable clear, memory and IO requests return `rspAddr` equal to the request address, whatever the stored values are.
- R8: Writes are encoded by `cfgWrSel`:
  - 0 to 7 load slice value n from `cfgWrData[6:0]`.
  - 8 loads the IO value from `cfgWrData[11:0]`.
  - 9 loads the enable from `cfgWrData[0]`.
  - Selects 10 to 15 change nothing.
  A write affects requests from the next cycle on. A request in the same cycle as the write still uses the old value.
- R9: Reset clears all nine remap values and the enable. During reset `rspValid`, `rspSpace`, `rspMiss` and `rspAddr` are 0.
- R10: `rspValid` equals `reqValid` of the previous cycle. In a cycle where `rspValid` is 0, `rspSpace` and `rspMiss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrSel | input | 4 | Register select for a write |
| cfgWrData | input | 12 | Register write data |
| reqValid | input | 1 | Request address is valid |
| reqAddr | input | 32 | Request address |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspSpace | output | 4 | One-hot space: memory, IO, config-address, config-data |
| rspAddr | output | 32 | Outbound (translated) address |
| rspMiss | output | 1 | Request hit no space |

## Verification
Every decode and translation result is due on the clock edge that follows the request, and a register write alters results from the next edge. The bench drives inputs on falling edges and reads the outputs at the following falling edge, exactly one rising edge later. For the write-ordering case, it issues a write together with a request and then repeats the request on the next cycle. It expects the old mapping first and the new one second.

// File: rtl/axl_pkg.sv
package axl_pkg;

  localparam int ADDR_W    = 32;
  localparam int NUM_WIN   = 8;
  localparam int WIN_VAL_W = 7;
  localparam int IO_VAL_W  = 12;
  localparam int SPACE_W   = 4;

  localparam int WIN_IDX_W = $clog2(NUM_WIN);
  localparam int WIN_LSB   = ADDR_W - WIN_VAL_W;
  localparam int MEM_TAG_W = ADDR_W - WIN_LSB - WIN_IDX_W;
  localparam int IO_LSB    = ADDR_W - IO_VAL_W;
  localparam int SEL_W     = $clog2(NUM_WIN + 2);
  localparam int DATA_W    = IO_VAL_W;

  localparam int SEL_IO    = NUM_WIN;
  localparam int SEL_EN    = NUM_WIN + 1;

  localparam logic [MEM_TAG_W-1:0] MEM_TAG   = MEM_TAG_W'(4'h8);
  localparam logic [IO_VAL_W-1:0]  IO_TAG    = 12'hA00;
  localparam logic [ADDR_W-1:0]    CFGA_ADDR = 32'hA010_0000;
  localparam logic [ADDR_W-1:0]    CFGD_ADDR = 32'hA020_0000;

  localparam int SP_MEM  = 0;
  localparam int SP_IO   = 1;
  localparam int SP_CFGA = 2;
  localparam int SP_CFGD = 3;

  typedef struct packed {
    logic                 capture;
    logic [SPACE_W-1:0]   space;
    logic                 miss;
    logic                 xlateMem;
    logic                 xlateIo;
    logic [WIN_VAL_W-1:0] memVal;
    logic [IO_VAL_W-1:0]  ioVal;
  } xlate_stb_t;

endpackage

// File: rtl/axl_ctrl.sv
module axl_ctrl
  import axl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgWrSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output xlate_stb_t        stb
);

  logic [WIN_VAL_W-1:0] winVal [NUM_WIN];
  logic [IO_VAL_W-1:0]  ioValQ;
  logic                 enQ;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          winVal[gi] <= '0;
        end else if (cfgWrEn && cfgWrSel == SEL_W'(gi)) begin
          winVal[gi] <= cfgWrData[WIN_VAL_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ioValQ <= '0;
      enQ    <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgWrSel == SEL_W'(SEL_IO)) ioValQ <= cfgWrData[IO_VAL_W-1:0];
      if (cfgWrSel == SEL_W'(SEL_EN)) enQ    <= cfgWrData[0];
    end
  end

  logic                 hitMem, hitIo, hitCfgA, hitCfgD;
  logic [WIN_IDX_W-1:0] winIdx;

  always_comb begin
    hitMem  = reqAddr[ADDR_W-1 -: MEM_TAG_W] == MEM_TAG;
    hitIo   = reqAddr[ADDR_W-1 -: IO_VAL_W] == IO_TAG;
    hitCfgA = reqAddr == CFGA_ADDR;
    hitCfgD = reqAddr == CFGD_ADDR;
    winIdx  = reqAddr[WIN_LSB +: WIN_IDX_W];

    stb                 = '0;
    stb.capture         = reqValid;
    stb.space[SP_MEM]   = hitMem;
    stb.space[SP_IO]    = hitIo;
    stb.space[SP_CFGA]  = hitCfgA;
    stb.space[SP_CFGD]  = hitCfgD;
    stb.miss            = !(hitMem || hitIo || hitCfgA || hitCfgD);
    stb.xlateMem        = enQ && hitMem;
    stb.xlateIo         = enQ && hitIo;
    stb.memVal          = winVal[winIdx];
    stb.ioVal           = ioValQ;
  end

endmodule

// File: rtl/axl_datapath.sv
module axl_datapath
  import axl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  xlate_stb_t         stb,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  output logic [SPACE_W-1:0] rspSpace,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic               rspMiss
);

  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    if (stb.xlateMem) begin
      nextAddr = {stb.memVal, reqAddr[WIN_LSB-1:0]};
    end else if (stb.xlateIo) begin
      nextAddr = {stb.ioVal, reqAddr[IO_LSB-1:0]};
    end else begin
      nextAddr = reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspSpace <= '0;
      rspAddr  <= '0;
      rspMiss  <= 1'b0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) begin
        rspSpace <= stb.space;
        rspAddr  <= nextAddr;
        rspMiss  <= stb.miss;
      end else begin
        rspSpace <= '0;
        rspMiss  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import axl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic [SEL_W-1:0]   cfgWrSel,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  output logic [SPACE_W-1:0] rspSpace,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic               rspMiss
);

  xlate_stb_t stb;

  axl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrSel  (cfgWrSel),
    .cfgWrData (cfgWrData),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .stb       (stb)
  );

  axl_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspSpace (rspSpace),
    .rspAddr  (rspAddr),
    .rspMiss  (rspMiss)
  );

endmodule

// File: rtl/addr_window_xlate_chk.sv
module addr_window_xlate_chk
  import axl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               rspValid,
  input logic [SPACE_W-1:0] rspSpace,
  input logic [ADDR_W-1:0]  rspAddr,
  input logic               rspMiss
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!rspValid && rspSpace == '0 && !rspMiss));

  // R1
  mem_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr[31:28] == 4'h8) |=>
      (rspSpace == 4'b0001 && rspAddr[24:0] == $past(reqAddr[24:0])));

  // R2
  io_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr[31:20] == 12'hA00) |=>
      (rspSpace == 4'b0010 && rspAddr[19:0] == $past(reqAddr[19:0])));

  // R3
  cfg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr == 32'hA010_0000) |=>
      (rspSpace == 4'b0100 && rspAddr == $past(reqAddr)));

  // R4
  miss_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspMiss |-> (rspSpace == '0 && rspValid));

  // R1
  space_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rspSpace));

endmodule

bind addr_window_xlate addr_window_xlate_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspSpace (rspSpace),
  .rspAddr  (rspAddr),
  .rspMiss  (rspMiss)
);

// File: tb/addr_window_xlate_test.sv
`timescale 1ns/1ps
module addr_window_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfgWrEn;
  logic [3:0]  cfgWrSel;
  logic [11:0] cfgWrData;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        rspValid;
  logic [3:0]  rspSpace;
  logic [31:0] rspAddr;
  logic        rspMiss;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [6:0]  mWin [8];
  logic [11:0] mIo;
  logic        mEn;

  always #4 clk = ~clk;

  addr_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspSpace(rspSpace), .rspAddr(rspAddr),
    .rspMiss(rspMiss)
  );

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expSpace(logic [31:0] a);
    if (a[31:28] == 4'h8)       return 4'b0001;
    if (a[31:20] == 12'hA00)    return 4'b0010;
    if (a == 32'hA010_0000)     return 4'b0100;
    if (a == 32'hA020_0000)     return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] expAddr(logic [31:0] a);
    if (mEn && a[31:28] == 4'h8)    return {mWin[a[27:25]], a[24:0]};
    if (mEn && a[31:20] == 12'hA00) return {mIo, a[19:0]};
    return a;
  endfunction

  task automatic checkRsp(string req, logic [31:0] a, logic [3:0] sp, logic [31:0] ea);
    checkEq(req, "rspValid", 32'(rspValid), 32'd1);
    checkEq(req, "rspSpace", 32'(rspSpace), 32'(sp));
    checkEq(req, "rspMiss", 32'(rspMiss), 32'(sp == 4'b0000));
    checkEq(req, "rspAddr", rspAddr, ea);
    if (a[31:0] === 32'hx) $display("unreachable");
  endtask

  task automatic wrCfg(logic [3:0] sel, logic [11:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel < 4'd8)       mWin[sel[2:0]] = data[6:0];
    else if (sel == 4'd8) mIo = data;
    else if (sel == 4'd9) mEn = data[0];
  endtask

  task automatic reqCheck(string req, logic [31:0] a);
    logic [3:0]  sp;
    logic [31:0] ea;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    sp = expSpace(a); ea = expAddr(a);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(req, a, sp, ea);
  endtask

  // R9: reset state and zeroed remap values
  task automatic t_reset();
    rst_n = 1'b0; cfgWrEn = 1'b0; cfgWrSel = '0; cfgWrData = '0;
    reqValid = 1'b0; reqAddr = '0;
    for (int i = 0; i < 8; i++) mWin[i] = '0;
    mIo = '0; mEn = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R9", "rspValid", 32'(rspValid), 0);
    checkEq("R9", "rspSpace", 32'(rspSpace), 0);
    checkEq("R9", "rspMiss", 32'(rspMiss), 0);
    checkEq("R9", "rspAddr", rspAddr, 0);
    rst_n = 1'b1;
    wrCfg(4'd9, 12'h001);
    reqCheck("R9", 32'h8A00_1234);
    checkEq("R9", "zeroed slice", rspAddr, 32'h0000_1234);
    reqCheck("R9", 32'hA004_5678);
    checkEq("R9", "zeroed io", rspAddr, 32'h0004_5678);
    wrCfg(4'd9, 12'h000);
  endtask

  // R7: disabled passthrough with nonzero values loaded
  task automatic t_disabled();
    for (int i = 0; i < 8; i++) wrCfg(4'(i), 12'(8'h40 + i));
    wrCfg(4'd8, 12'h5A5);
    reqCheck("R7", 32'h8E12_3456);
    checkEq("R7", "mem passthrough", rspAddr, 32'h8E12_3456);
    reqCheck("R7", 32'hA00A_BCDE);
    checkEq("R7", "io passthrough", rspAddr, 32'hA00A_BCDE);
  endtask

  // R1 R5: each slice remapped
  task automatic t_mem_windows();
    wrCfg(4'd9, 12'h001);
    wrCfg(4'd0, 12'h075);
    reqCheck("R5", 32'h8000_0000);
    checkEq("R5", "example", rspAddr, 32'hEA00_0000);
    for (int i = 0; i < 8; i++) begin
      reqCheck("R1", 32'h8000_0000 | (32'(i) << 25) | 32'h0123_4567 & 32'h01FF_FFFF);
    end
    reqCheck("R5", 32'h8FFF_FFFF);
  endtask

  // R2 R6: IO remap
  task automatic t_io();
    wrCfg(4'd8, 12'hC3F);
    reqCheck("R6", 32'hA00F_FFFF);
    checkEq("R6", "io top", rspAddr, 32'hC3FF_FFFF);
    reqCheck("R2", 32'hA000_0000);
  endtask

  // R3: config register locations
  task automatic t_cfg();
    reqCheck("R3", 32'hA010_0000);
    reqCheck("R3", 32'hA020_0000);
  endtask

  // R4: addresses outside every space
  task automatic t_miss();
    reqCheck("R4", 32'h7FFF_FFFF);
    reqCheck("R4", 32'h9000_0000);
    reqCheck("R4", 32'hA010_0004);
    reqCheck("R4", 32'hA01F_FFFC);
    reqCheck("R4", 32'hA020_0001);
    reqCheck("R4", 32'hFFFF_FFFF);
  endtask

  // R8: write ordering and ignored selects
  task automatic t_write_timing();
    logic [31:0] a;
    logic [31:0] eOld;
    logic [31:0] eNew;
    a = 32'h8200_0010;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = 4'd1; cfgWrData = 12'h011;
    reqValid = 1'b1; reqAddr = a;
    eOld = expAddr(a);
    @(negedge clk);
    cfgWrEn = 1'b0;
    mWin[1] = 7'h11;
    eNew = expAddr(a);
    checkRsp("R8", a, 4'b0001, eOld);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R8", a, 4'b0001, eNew);
    checkEq("R8", "new value", rspAddr, 32'h2200_0010);
    for (int s = 10; s < 16; s++) begin
      @(negedge clk);
      cfgWrEn = 1'b1; cfgWrSel = 4'(s); cfgWrData = 12'hFFF;
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
    reqCheck("R8", 32'h8200_0010);
    reqCheck("R8", 32'hA001_0000);
  endtask

  // R10: idle cycles and back-to-back requests
  task automatic t_idle();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h9000_0000;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'hA020_0000;
    checkRsp("R10", 32'h9000_0000, 4'b0000, 32'h9000_0000);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R10", 32'hA020_0000, 4'b1000, 32'hA020_0000);
    @(negedge clk);
    checkEq("R10", "idle valid", 32'(rspValid), 0);
    checkEq("R10", "idle space", 32'(rspSpace), 0);
    checkEq("R10", "idle miss", 32'(rspMiss), 0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_mem_windows();
    t_io();
    t_cfg();
    t_miss();
    t_write_timing();
    t_idle();
    done = 1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule